// File: doc/BRIEF.md
# Exclusive Access Monitor for a Shared Count Register

This block is a small register slave with single-beat AXI-style address, data and response channels. Its job is to hold shared words, such as reference counts that decide whether a peripheral stays powered, and to give software a safe read-modify-write on them. An exclusive read places a reservation on one word for one requester. A later exclusive write succeeds only if that same requester's reservation on that word is still intact. Otherwise the write is dropped and the failure is reported in the write response, so the software retries.

A requester is not identified by the fabric port alone. Several cores often share one port, and exclusive accesses from two of them would then be mistaken for the same requester. Two things together form the identity used for matching: a port field and a core field, both taken from the transaction ID. The position and width of each field are parameters. ID bits outside both fields are treated as per-transaction tags and play no part in matching.

There is one reservation slot, and each transfer is a single beat. Writes and reads are each accepted one at a time. The response for an accepted transfer appears on the cycle after the acceptance edge.

Top module: `xmon_top`

## Requirements
- R1: After reset, b_valid and r_valid are low, every register reads 0, and no reservation exists, so an exclusive write fails.
- R2: A write with aw_lock low always stores w_data and returns b_resp 2'b00 (OKAY). A read with ar_lock low returns the stored word with r_resp 2'b00.
- R3: A read with ar_lock high returns the stored word with r_resp 2'b01 (EXOKAY) and records the requester key and the address.
- R4: An exclusive write whose key and address match a live reservation stores the data, returns b_resp 2'b01 and clears the reservation, so repeating the same write fails.
- R5: An exclusive write without a matching live reservation leaves all registers unchanged and returns b_resp 2'b00.
- R6: The requester key is {id[7:6], id[1:0]} (port field, core field) with the default parameters. Bits id[5:2] are ignored. Two cores behind one port, or one core number on two ports, are different requesters.
- R7: Any read or write that reaches the reserved address and is not the matching exclusive write cancels the reservation. This includes normal accesses, accesses from other requesters, and failed exclusive writes.
- R8: Accesses to other addresses leave the reservation in place, including a failed exclusive write by the reserving requester.
- R9: A new exclusive read from any requester replaces the existing reservation.
- R10: A write is accepted (aw_ready and w_ready high) when aw_valid and w_valid are both high and no write response is pending. A read is accepted when ar_valid is high, no read response is pending and no write is accepted in that cycle. Responses appear one cycle after acceptance, echo the ID, and hold until b_ready or r_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| aw_id | input | 8 | Write transaction ID (port, tag, core fields) |
| aw_addr | input | 2 | Write word address |
| aw_lock | input | 1 | Write is exclusive |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | 16 | Write data |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_id | output | 8 | Write response ID |
| b_resp | output | 2 | Write response code (00 OKAY, 01 EXOKAY) |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_id | input | 8 | Read transaction ID |
| ar_addr | input | 2 | Read word address |
| ar_lock | input | 1 | Read is exclusive |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data taken |
| r_id | output | 8 | Read response ID |
| r_data | output | 16 | Read data |
| r_resp | output | 2 | Read response code |

## Verification
The bench uses the default parameters: an 8-bit ID with a 2-bit port field at the top, a 2-bit core field at the bottom and four tag bits between them, plus four 16-bit words. With this layout, two cores on one port can release the same count concurrently. The bench can also vary only the tag bits, which must not matter, or vary only the port, which must. Four words are enough to show that traffic to other addresses leaves a reservation standing, while an access to the reserved word cancels it.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOKAY = 2'b01
   } resp_e;
endpackage

// File: rtl/xmon_key.sv
module xmon_key #(
   parameter int ID_W     = 8,
   parameter int PORT_LSB = 6,
   parameter int PORT_W   = 2,
   parameter int CORE_LSB = 0,
   parameter int CORE_W   = 2,
   localparam int KEY_W   = PORT_W + CORE_W
) (
   input  logic [ID_W-1:0]  id,
   output logic [KEY_W-1:0] key
);
   if (PORT_W < 1 || PORT_LSB + PORT_W > ID_W) begin : g_bad_port
      $error("port field does not fit in the ID");
   end
   if (CORE_W < 0 || CORE_LSB + CORE_W > ID_W) begin : g_bad_core
      $error("core field does not fit in the ID");
   end

   // R6: key built from port field and (optionally) the core field
   if (CORE_W > 0) begin : g_with_core
      assign key = {id[PORT_LSB +: PORT_W], id[CORE_LSB +: CORE_W]};
   end else begin : g_port_only
      assign key = id[PORT_LSB +: PORT_W];
   end

   logic unused_tag_bits;
   assign unused_tag_bits = ^id;
endmodule

// File: rtl/xmon_regs.sv
module xmon_regs #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2,
   localparam int NREG  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [NREG-1:0][DATA_W-1:0] mem_q;

   for (genvar g = 0; g < NREG; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem_q[g] <= '0;
         else if (we && waddr == ADDR_W'(g))
            mem_q[g] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

   // R5
   regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mem_q));
endmodule

// File: rtl/xmon_resv.sv
module xmon_resv #(
   parameter int KEY_W  = 4,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic              wr_excl,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              rd_fire,
   input  logic              rd_excl,
   input  logic [KEY_W-1:0]  rd_key,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              wr_pass,
   output logic              resv_valid
);
   logic              valid_q;
   logic [KEY_W-1:0]  key_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_hit, rd_hit;

   assign wr_hit     = valid_q && (wr_addr == addr_q);
   assign rd_hit     = valid_q && (rd_addr == addr_q);
   assign wr_pass    = wr_excl && wr_hit && (wr_key == key_q);
   assign resv_valid = valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         key_q   <= '0;
         addr_q  <= '0;
      end else if (rd_fire && rd_excl) begin
         valid_q <= 1'b1;
         key_q   <= rd_key;
         addr_q  <= rd_addr;
      end else if ((rd_fire && rd_hit) || (wr_fire && wr_hit)) begin
         valid_q <= 1'b0;
      end
   end

   // R3
   excl_read_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && rd_excl |=> valid_q);
   // R4
   pass_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && wr_pass |=> !valid_q);
   // R8
   other_addr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && wr_fire && !wr_hit && !rd_fire |=> valid_q);
endmodule

// File: rtl/xmon_top.sv
module xmon_top
   import xmon_pkg::*;
#(
   parameter int ID_W     = 8,
   parameter int PORT_LSB = 6,
   parameter int PORT_W   = 2,
   parameter int CORE_LSB = 0,
   parameter int CORE_W   = 2,
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              aw_lock,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [ID_W-1:0]   b_id,
   output logic [1:0]        b_resp,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ID_W-1:0]   ar_id,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic              ar_lock,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [ID_W-1:0]   r_id,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp
);
   localparam int KEY_W = PORT_W + CORE_W;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_size
      $error("address and data widths must be positive");
   end

   logic              wr_fire, rd_fire, wr_pass, reg_we, resv_valid;
   logic [KEY_W-1:0]  wr_key, rd_key;
   logic [DATA_W-1:0] rd_word;
   logic              b_valid_q, r_valid_q;
   logic [ID_W-1:0]   b_id_q, r_id_q;
   resp_e             b_resp_q, r_resp_q;
   logic [DATA_W-1:0] r_data_q;

   // R10: one write or one read per cycle, writes first
   assign wr_fire  = aw_valid && w_valid && !b_valid_q;
   assign rd_fire  = ar_valid && !r_valid_q && !wr_fire;
   assign aw_ready = wr_fire;
   assign w_ready  = wr_fire;
   assign ar_ready = rd_fire;
   assign reg_we   = wr_fire && (!aw_lock || wr_pass);

   xmon_key #(.ID_W(ID_W), .PORT_LSB(PORT_LSB), .PORT_W(PORT_W),
              .CORE_LSB(CORE_LSB), .CORE_W(CORE_W))
      u_wkey (.id(aw_id), .key(wr_key));
   xmon_key #(.ID_W(ID_W), .PORT_LSB(PORT_LSB), .PORT_W(PORT_W),
              .CORE_LSB(CORE_LSB), .CORE_W(CORE_W))
      u_rkey (.id(ar_id), .key(rd_key));

   xmon_resv #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_resv (
      .clk(clk), .rst_n(rst_n),
      .wr_fire(wr_fire), .wr_excl(aw_lock), .wr_key(wr_key), .wr_addr(aw_addr),
      .rd_fire(rd_fire), .rd_excl(ar_lock), .rd_key(rd_key), .rd_addr(ar_addr),
      .wr_pass(wr_pass), .resv_valid(resv_valid));

   xmon_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(aw_addr), .wdata(w_data),
      .raddr(ar_addr), .rdata(rd_word));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_valid_q <= 1'b0;
         b_id_q    <= '0;
         b_resp_q  <= RESP_OKAY;
      end else if (wr_fire) begin
         b_valid_q <= 1'b1;
         b_id_q    <= aw_id;
         b_resp_q  <= (aw_lock && wr_pass) ? RESP_EXOKAY : RESP_OKAY;
      end else if (b_ready) begin
         b_valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_valid_q <= 1'b0;
         r_id_q    <= '0;
         r_resp_q  <= RESP_OKAY;
         r_data_q  <= '0;
      end else if (rd_fire) begin
         r_valid_q <= 1'b1;
         r_id_q    <= ar_id;
         r_resp_q  <= ar_lock ? RESP_EXOKAY : RESP_OKAY;
         r_data_q  <= rd_word;
      end else if (r_ready) begin
         r_valid_q <= 1'b0;
      end
   end

   assign b_valid = b_valid_q;
   assign b_id    = b_id_q;
   assign b_resp  = b_resp_q;
   assign r_valid = r_valid_q;
   assign r_id    = r_id_q;
   assign r_data  = r_data_q;
   assign r_resp  = r_resp_q;

   // R10
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_valid && !b_ready |=> b_valid && $stable(b_resp) && $stable(b_id));
   // R10
   r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid && !r_ready |=> r_valid && $stable(r_data) && $stable(r_id));
   // R4
   excl_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && aw_lock && wr_pass |=> b_valid && b_resp == RESP_EXOKAY);
   // R5
   excl_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && aw_lock && !wr_pass |=> b_valid && b_resp == RESP_OKAY);
   // R2
   plain_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire && !aw_lock |=> b_resp == RESP_OKAY);
   // R3
   excl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && ar_lock |=> r_valid && r_resp == RESP_EXOKAY && resv_valid);
endmodule

// File: tb/tb_xmon_top.sv
module tb_xmon_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        aw_valid = 0, aw_lock = 0, w_valid = 0, b_ready = 1;
   logic        ar_valid = 0, ar_lock = 0, r_ready = 1;
   logic [7:0]  aw_id = 0, ar_id = 0;
   logic [1:0]  aw_addr = 0, ar_addr = 0;
   logic [15:0] w_data = 0;
   logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
   logic [7:0]  b_id, r_id;
   logic [1:0]  b_resp, r_resp;
   logic [15:0] r_data;

   int total = 0, bad = 0;
   bit done = 0;
   bit exp_bv = 0, exp_rv = 0;
   int model_mem [4];
   bit rv = 0;
   logic [3:0] rk = 0;
   logic [1:0] ra = 0;

   localparam logic [7:0] CA  = 8'h40; // port 1, core 0
   localparam logic [7:0] CB  = 8'h41; // port 1, core 1
   localparam logic [7:0] CA2 = 8'h7C; // port 1, core 0, other tag bits
   localparam logic [7:0] PX  = 8'h80; // port 2, core 0

   xmon_top dut (.*);

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] key_of(input logic [7:0] id);
      return {id[7:6], id[1:0]};
   endfunction

   // per-clock comparison of response valids with the model
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(b_valid == exp_bv, "R10 b_valid", b_valid, exp_bv);
         check(r_valid == exp_rv, "R10 r_valid", r_valid, exp_rv);
      end
   end

   task automatic wr(input logic [7:0] id, input logic [1:0] a, input logic [15:0] d,
                     input bit lk, input string req);
      bit hit, pass;
      hit  = rv && ra == a;
      pass = lk && hit && rk == key_of(id);
      aw_valid = 1; w_valid = 1; aw_id = id; aw_addr = a; w_data = d; aw_lock = lk;
      #1 check(aw_ready && w_ready, "R10 aw_ready", aw_ready, 1);
      @(posedge clk);
      exp_bv = 1;
      if (!lk || pass) model_mem[a] = d;
      if (hit) rv = 0;
      @(negedge clk);
      aw_valid = 0; w_valid = 0; aw_lock = 0;
      check(b_resp == (pass ? 2'b01 : 2'b00), req, b_resp, pass ? 1 : 0);
      check(b_id == id, "R10 b_id", b_id, id);
      @(posedge clk);
      exp_bv = 0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] id, input logic [1:0] a, input bit lk,
                     input string req);
      int ed;
      ed = model_mem[a];
      ar_valid = 1; ar_id = id; ar_addr = a; ar_lock = lk;
      #1 check(ar_ready, "R10 ar_ready", ar_ready, 1);
      @(posedge clk);
      exp_rv = 1;
      if (lk) begin rv = 1; rk = key_of(id); ra = a; end
      else if (rv && ra == a) rv = 0;
      @(negedge clk);
      ar_valid = 0; ar_lock = 0;
      check(r_data == ed[15:0], req, r_data, ed);
      check(r_resp == (lk ? 2'b01 : 2'b00), req, r_resp, lk ? 1 : 0);
      check(r_id == id, "R10 r_id", r_id, id);
      @(posedge clk);
      exp_rv = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) model_mem[i] = 0;
      repeat (3) @(negedge clk);
      check(b_valid == 0 && r_valid == 0, "R1 valids in reset", {b_valid, r_valid}, 0);
      rst_n = 1;
      @(negedge clk);
      // R1: reset contents and no reservation
      for (int i = 0; i < 4; i++) rd(CB, 2'(i), 0, "R1 reset word");
      wr(CA, 1, 16'h0007, 1, "R1 R5 excl write after reset fails");
      rd(CA, 1, 0, "R5 word unchanged");
      // R2: plain write and read
      wr(CA, 1, 16'h0002, 0, "R2 plain write");
      rd(CB, 1, 0, "R2 plain read");
      // R9 R4 R6: two cores on one port release the same count
      rd(CA, 1, 1, "R3 excl read core0");
      rd(CB, 1, 1, "R9 excl read core1 replaces");
      wr(CB, 1, 16'h0001, 1, "R4 core1 excl write passes");
      wr(CA, 1, 16'h0001, 1, "R6 core0 excl write fails");
      rd(CB, 1, 0, "R4 count is 1");
      rd(CA, 1, 1, "R3 core0 retries read");
      wr(CA, 1, 16'h0000, 1, "R4 core0 retry passes");
      wr(CA, 1, 16'h0055, 1, "R4 reservation cleared after pass");
      rd(CA, 1, 0, "R4 count is 0");
      // R6: tag bits ignored, port bits matter
      rd(CA, 2, 1, "R3 excl read");
      wr(CA2, 2, 16'h1234, 1, "R6 tag bits ignored");
      rd(CA, 2, 1, "R3 excl read");
      wr(PX, 2, 16'h9999, 1, "R6 other port same core fails");
      rd(CB, 2, 0, "R6 word unchanged");
      // R7: cancellations
      rd(CA, 3, 1, "R3 excl read");
      rd(CB, 3, 0, "R7 plain read by other");
      wr(CA, 3, 16'h0AAA, 1, "R7 cancelled by read");
      rd(CA, 3, 1, "R3 excl read");
      wr(CB, 3, 16'h0BBB, 0, "R7 plain write by other");
      wr(CA, 3, 16'h0CCC, 1, "R7 cancelled by write");
      rd(CA, 3, 0, "R7 holds plain write value");
      rd(CA, 3, 1, "R3 excl read");
      wr(CB, 3, 16'h0DDD, 1, "R7 failed excl from other");
      wr(CA, 3, 16'h0EEE, 1, "R7 cancelled by failed excl");
      rd(CA, 3, 1, "R3 excl read");
      rd(CA, 3, 0, "R7 own plain read");
      wr(CA, 3, 16'h0F0F, 1, "R7 cancelled by own plain read");
      // R8: other addresses leave it standing
      rd(CA, 3, 1, "R3 excl read");
      wr(CB, 0, 16'h0111, 0, "R8 plain write elsewhere");
      rd(CB, 2, 0, "R8 plain read elsewhere");
      wr(CA, 2, 16'h0222, 1, "R8 own excl write elsewhere fails");
      wr(CA, 3, 16'h0333, 1, "R8 reservation survives");
      rd(CB, 2, 0, "R8 word 2 unchanged");
      rd(CB, 3, 0, "R8 word 3 updated");
      // R10: write response backpressure
      b_ready = 0;
      aw_valid = 1; w_valid = 1; aw_id = CB; aw_addr = 0; w_data = 16'h4444; aw_lock = 0;
      @(posedge clk);
      exp_bv = 1; model_mem[0] = 16'h4444;
      @(negedge clk);
      aw_id = CA; w_data = 16'h5555;
      #1 check(aw_ready == 0, "R10 no accept while B pending", aw_ready, 0);
      @(negedge clk);
      check(b_id == CB && b_resp == 2'b00, "R10 B held", b_id, CB);
      aw_valid = 0; w_valid = 0;
      b_ready = 1;
      @(posedge clk);
      exp_bv = 0;
      @(negedge clk);
      rd(CB, 0, 0, "R10 only first write stored");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule